// File: doc/BRIEF.md
# Register Timing Constraint Checker

This block judges register endpoints against their timing limits once evaluation of a simulated clock cycle has finished. Each input item names one group of 32 packed signals by its position, gives the latest arrival time seen in that group, and carries one 32-bit word that holds the setup and hold requirements. The block compares the arrival with a programmable clock period and with those requirements. For every broken limit it writes one event record. The record holds an event code, the simulated cycle number, the absolute group index, a signed slack, the arrival, and the limit that was broken.

Items come in on a valid/ready stream. Events leave on a valid/ready stream that feeds an event FIFO. A full FIFO shows up as a low ready, and that stalls the input stream, so no event is lost. A strobe from the simulation driver marks the end of each simulated cycle and advances the cycle number.

Top module: `tvc_top`

## Requirements
- R1: After synchronous reset, `evt_valid` is 0, `in_ready` is 1 and the cycle number is 0.
- R2: The cycle number increments by one on each clock where `cyc_end` is 1. An event carries the cycle number that was current when its item was accepted (the value before any increment on that same edge).
- R3: A setup event (code 4) is raised when the arrival is nonzero and arrival + setup is greater than the period. The sum is formed at 32 bits, so 65535 + 65535 does not wrap. Its slack is period − arrival − setup as a signed 32-bit value, and its limit field is the setup time.
- R4: When the arrival is zero, no setup event is raised, whatever the setup time and period are.
- R5: A hold event (code 5) is raised whenever the arrival is less than the hold time, and this includes an arrival of zero. Its slack is arrival − hold as a signed 32-bit value, and its limit field is the hold time.
- R6: In the constraint word, setup occupies bits [31:16] and hold occupies bits [15:0]. When one item breaks both limits, the setup event is emitted before the hold event.
- R7: The group field equals `cfg_base + in_group`, taken modulo 2^GRP_W.
- R8: While any event of an accepted item has not yet been taken, `in_ready` is 0. An offered event holds its value until `evt_ready` is 1, and every raised event is eventually emitted exactly once.
- R9: Equality is not a violation. arrival + setup equal to the period raises no setup event, and arrival equal to the hold time raises no hold event.
- R10: Only codes 4 and 5 appear on `evt_kind`. Codes 0 to 3 (stop, finish, display, assertion failure) belong to other event sources and are never produced here.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_period | input | 16 | Clock period in ps |
| cfg_base | input | GRP_W | Base offset added to group positions |
| cyc_end | input | 1 | End-of-cycle strobe |
| in_valid | input | 1 | Input item valid |
| in_ready | output | 1 | Input item accepted when high with valid |
| in_group | input | GRP_W | Group position |
| in_arrival | input | 16 | Latest arrival of the group in ps |
| in_cword | input | 32 | {setup[31:16], hold[15:0]} in ps |
| evt_valid | output | 1 | Event offered |
| evt_ready | input | 1 | Event FIFO can take an event |
| evt_kind | output | 3 | Event code, 4 = setup, 5 = hold |
| evt_cycle | output | CYC_W | Cycle number of the item |
| evt_group | output | GRP_W | Absolute group index |
| evt_slack | output | 32 | Signed slack in ps |
| evt_arrival | output | 16 | Arrival in ps |
| evt_limit | output | 16 | Setup or hold time that was broken |

## Verification
The assertions take the configuration inputs `cfg_period` and `cfg_base` to be static while an item is inside the block. The bench changes them only when no event is outstanding. They also take it that the input item stays unchanged while `in_valid` is 1 and `in_ready` is 0, and the bench drivers hold every field until the handshake completes. The end-of-cycle strobe is allowed on any clock, including clocks where an item is being accepted. The bench pulses it freely during the randomized phase to cover that overlap.

// File: rtl/tvc_pkg.sv
package tvc_pkg;

    localparam int PS_W  = 16;
    localparam int SLK_W = 32;
    localparam int CW_W  = 2 * PS_W;

    typedef logic [PS_W-1:0]         ps_t;
    typedef logic signed [SLK_W-1:0] slack_t;

    typedef enum logic [2:0] {
        EVK_STOP    = 3'd0,
        EVK_FINISH  = 3'd1,
        EVK_DISPLAY = 3'd2,
        EVK_ASSERT  = 3'd3,
        EVK_SETUP   = 3'd4,
        EVK_HOLD    = 3'd5
    } evk_e;

    typedef struct packed {
        logic   setup_hit;
        logic   hold_hit;
        slack_t setup_slack;
        slack_t hold_slack;
        ps_t    setup_ps;
        ps_t    hold_ps;
    } verdict_t;

    function automatic ps_t cw_setup(input logic [CW_W-1:0] cw);
        return cw[CW_W-1:PS_W];
    endfunction

    function automatic ps_t cw_hold(input logic [CW_W-1:0] cw);
        return cw[PS_W-1:0];
    endfunction

    function automatic logic [SLK_W-1:0] widen(input ps_t v);
        return SLK_W'(v);
    endfunction

endpackage

// File: rtl/tvc_cycle_count.sv
module tvc_cycle_count #(
    parameter int CYC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [CYC_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (step) count <= count + CYC_W'(1);
    end

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> count == $past(count) + CYC_W'(1)); // R2

    AST_CYCLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(count)); // R2

endmodule

// File: rtl/tvc_judge.sv
module tvc_judge
    import tvc_pkg::*;
(
    input  ps_t             period,
    input  ps_t             arrival,
    input  logic [CW_W-1:0] cword,
    output verdict_t        verdict
);

    logic [SLK_W-1:0] arr_w, su_w, ho_w, per_w, need_w;

    always_comb begin
        arr_w  = widen(arrival);
        su_w   = widen(cw_setup(cword));
        ho_w   = widen(cw_hold(cword));
        per_w  = widen(period);
        need_w = arr_w + su_w;

        verdict.setup_ps    = cw_setup(cword);
        verdict.hold_ps     = cw_hold(cword);
        verdict.setup_hit   = (arrival != '0) && (need_w > per_w);
        verdict.hold_hit    = arrival < cw_hold(cword);
        verdict.setup_slack = $signed(per_w - need_w);
        verdict.hold_slack  = $signed(arr_w - ho_w);
    end

endmodule

// File: rtl/tvc_emitter.sv
module tvc_emitter
    import tvc_pkg::*;
#(
    parameter int GRP_W = 12,
    parameter int CYC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  verdict_t         verdict,
    input  ps_t              arrival,
    input  logic [GRP_W-1:0] group,
    input  logic [CYC_W-1:0] cycle,
    output logic             busy,
    output logic             evt_valid,
    input  logic             evt_ready,
    output evk_e             evt_kind,
    output logic [CYC_W-1:0] evt_cycle,
    output logic [GRP_W-1:0] evt_group,
    output slack_t           evt_slack,
    output ps_t              evt_arrival,
    output ps_t              evt_limit
);

    logic             pend_s, pend_h;
    slack_t           s_slack_q, h_slack_q;
    ps_t              su_q, ho_q, arr_q;
    logic [GRP_W-1:0] grp_q;
    logic [CYC_W-1:0] cyc_q;
    logic             fire;

    assign busy      = pend_s | pend_h;
    assign evt_valid = busy;
    assign fire      = evt_valid & evt_ready;

    always_comb begin
        evt_kind    = pend_s ? EVK_SETUP : EVK_HOLD;
        evt_slack   = pend_s ? s_slack_q : h_slack_q;
        evt_limit   = pend_s ? su_q : ho_q;
        evt_cycle   = cyc_q;
        evt_group   = grp_q;
        evt_arrival = arr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_s <= 1'b0;
            pend_h <= 1'b0;
        end else if (load) begin
            pend_s <= verdict.setup_hit;
            pend_h <= verdict.hold_hit;
        end else if (fire) begin
            if (pend_s) pend_s <= 1'b0;
            else        pend_h <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            s_slack_q <= verdict.setup_slack;
            h_slack_q <= verdict.hold_slack;
            su_q      <= verdict.setup_ps;
            ho_q      <= verdict.hold_ps;
            arr_q     <= arrival;
            grp_q     <= group;
            cyc_q     <= cycle;
        end
    end

    AST_EVT_STABLE: assert property (@(posedge clk) disable iff (rst)
        evt_valid && !evt_ready |=> evt_valid &&
        $stable({evt_kind, evt_cycle, evt_group, evt_slack, evt_arrival, evt_limit})); // R8

    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> (evt_kind == EVK_SETUP || evt_kind == EVK_HOLD)); // R10

    AST_SETUP_NONZERO: assert property (@(posedge clk) disable iff (rst)
        evt_valid && evt_kind == EVK_SETUP |-> evt_arrival != '0); // R4

    AST_SETUP_NEG: assert property (@(posedge clk) disable iff (rst)
        evt_valid && evt_kind == EVK_SETUP |-> evt_slack < 0); // R3

    AST_HOLD_NEG: assert property (@(posedge clk) disable iff (rst)
        evt_valid && evt_kind == EVK_HOLD |-> evt_slack < 0 && evt_arrival < evt_limit); // R5

    AST_HOLD_AFTER: assert property (@(posedge clk) disable iff (rst)
        fire && evt_kind == EVK_HOLD |=> !evt_valid || $changed(evt_cycle) ||
        $changed(evt_group) || evt_kind == EVK_SETUP); // R6

endmodule

// File: rtl/tvc_top.sv
module tvc_top
    import tvc_pkg::*;
#(
    parameter int GRP_W = 12,
    parameter int CYC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      cfg_period,
    input  logic [GRP_W-1:0] cfg_base,
    input  logic             cyc_end,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [GRP_W-1:0] in_group,
    input  logic [15:0]      in_arrival,
    input  logic [31:0]      in_cword,
    output logic             evt_valid,
    input  logic             evt_ready,
    output logic [2:0]       evt_kind,
    output logic [CYC_W-1:0] evt_cycle,
    output logic [GRP_W-1:0] evt_group,
    output logic [31:0]      evt_slack,
    output logic [15:0]      evt_arrival,
    output logic [15:0]      evt_limit
);

    logic [CYC_W-1:0] cyc_now;
    verdict_t         verdict;
    logic             busy, load;
    logic [GRP_W-1:0] abs_group;
    evk_e             kind;
    slack_t           slack;

    assign in_ready  = !busy;
    assign load      = in_valid & in_ready;
    assign abs_group = cfg_base + in_group;
    assign evt_kind  = kind;
    assign evt_slack = slack;

    tvc_cycle_count #(.CYC_W(CYC_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .step  (cyc_end),
        .count (cyc_now)
    );

    tvc_judge u_judge (
        .period  (cfg_period),
        .arrival (in_arrival),
        .cword   (in_cword),
        .verdict (verdict)
    );

    tvc_emitter #(.GRP_W(GRP_W), .CYC_W(CYC_W)) u_emit (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .verdict     (verdict),
        .arrival     (in_arrival),
        .group       (abs_group),
        .cycle       (cyc_now),
        .busy        (busy),
        .evt_valid   (evt_valid),
        .evt_ready   (evt_ready),
        .evt_kind    (kind),
        .evt_cycle   (evt_cycle),
        .evt_group   (evt_group),
        .evt_slack   (slack),
        .evt_arrival (evt_arrival),
        .evt_limit   (evt_limit)
    );

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> !in_ready); // R8

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> !evt_valid && in_ready); // R1

endmodule

// File: tb/tvc_top_tb_top.sv
module tvc_top_tb_top;

    localparam int GRP_W = 12;
    localparam int CYC_W = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [15:0]      cfg_period = 16'd1000;
    logic [GRP_W-1:0] cfg_base = '0;
    logic             cyc_end = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [GRP_W-1:0] in_group = '0;
    logic [15:0]      in_arrival = '0;
    logic [31:0]      in_cword = '0;
    logic             evt_valid;
    logic             evt_ready = 1'b1;
    logic [2:0]       evt_kind;
    logic [CYC_W-1:0] evt_cycle;
    logic [GRP_W-1:0] evt_group;
    logic [31:0]      evt_slack;
    logic [15:0]      evt_arrival;
    logic [15:0]      evt_limit;

    always #10 clk = ~clk;

    tvc_top #(.GRP_W(GRP_W), .CYC_W(CYC_W)) dut_i (
        .clk(clk), .rst(rst), .cfg_period(cfg_period), .cfg_base(cfg_base),
        .cyc_end(cyc_end), .in_valid(in_valid), .in_ready(in_ready),
        .in_group(in_group), .in_arrival(in_arrival), .in_cword(in_cword),
        .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_kind(evt_kind),
        .evt_cycle(evt_cycle), .evt_group(evt_group), .evt_slack(evt_slack),
        .evt_arrival(evt_arrival), .evt_limit(evt_limit)
    );

    typedef struct {
        int kind; int cyc; int grp; int slack; int arr; int lim;
    } ev_t;

    ev_t exp_q[$];
    int  checks = 0;
    int  errors = 0;
    int  m_cycle = 0;
    int  tick = 0;
    int  wd = 0;
    int  rdy_mode = 0;
    bit  cyc_mode = 0;
    bit  done = 0;
    int unsigned lcg = 32'h1234_5678;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // reference model: compute events for an accepted item
    task automatic model_accept();
        int a, su, ho, per, g;
        ev_t e;
        a   = int'(in_arrival);
        su  = int'(in_cword[31:16]);
        ho  = int'(in_cword[15:0]);
        per = int'(cfg_period);
        g   = (int'(cfg_base) + int'(in_group)) % (1 << GRP_W);
        if (a > 0 && a + su > per) begin
            e = '{4, m_cycle, g, per - a - su, a, su};
            exp_q.push_back(e);
        end
        if (a < ho) begin
            e = '{5, m_cycle, g, a - ho, a, ho};
            exp_q.push_back(e);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(in_ready === (exp_q.size() == 0), "R8 in_ready", longint'(in_ready),
                longint'(exp_q.size() == 0));
            chk(evt_valid === (exp_q.size() != 0), "R3/R4/R5/R9 evt_valid",
                longint'(evt_valid), longint'(exp_q.size() != 0));
            if (evt_valid && exp_q.size() != 0) begin
                chk(int'(evt_kind) == exp_q[0].kind, "R6 R10 kind", longint'(evt_kind),
                    longint'(exp_q[0].kind));
                chk(int'(evt_cycle) == exp_q[0].cyc, "R2 cycle", longint'(evt_cycle),
                    longint'(exp_q[0].cyc));
                chk(int'(evt_group) == exp_q[0].grp, "R7 group", longint'(evt_group),
                    longint'(exp_q[0].grp));
                chk($signed(evt_slack) == exp_q[0].slack, "R3/R5 slack",
                    longint'($signed(evt_slack)), longint'(exp_q[0].slack));
                chk(int'(evt_arrival) == exp_q[0].arr, "R3/R5 arrival",
                    longint'(evt_arrival), longint'(exp_q[0].arr));
                chk(int'(evt_limit) == exp_q[0].lim, "R6 limit", longint'(evt_limit),
                    longint'(exp_q[0].lim));
                if (evt_ready) void'(exp_q.pop_front());
            end
            if (in_valid && in_ready) model_accept();
            if (cyc_end) m_cycle++;
        end
    end

    // output-side ready and cycle strobe, changed away from the edge
    always @(posedge clk) begin
        #5;
        tick++;
        case (rdy_mode)
            0:       evt_ready = 1'b1;
            1:       evt_ready = (tick % 3) != 0;
            default: evt_ready = (tick % 8) >= 6;
        endcase
        cyc_end = cyc_mode && !rst && ((tick % 5) == 0);
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", wd, 150000);
            finish_run();
        end
    end

    task automatic send(input int pos, input int arr, input int su, input int ho);
        in_group   = GRP_W'(pos);
        in_arrival = 16'(arr);
        in_cword   = {16'(su), 16'(ho)};
        in_valid   = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #5;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while ((exp_q.size() != 0 || evt_valid) && n < 2000) begin
            @(posedge clk);
            n++;
        end
        repeat (3) @(posedge clk);
        #5;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5;
        rst = 1'b0;
        @(negedge clk);
        chk(evt_valid === 1'b0, "R1 evt_valid after reset", longint'(evt_valid), 0);
        chk(in_ready === 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);
        @(posedge clk);
        #5;

        // R1 R2: first violation carries cycle 0
        send(1, 1200, 0, 0);         // R3 setup slack -200, cycle 0
        send(2, 200, 100, 50);       // no event
        send(3, 900, 150, 0);        // R3 slack -50
        send(4, 0, 2000, 0);         // R4 suppressed
        send(5, 0, 2000, 30);        // R4 R5 hold only at zero arrival
        send(6, 950, 100, 960);      // R6 both, setup first
        send(7, 900, 100, 0);        // R9 equal setup
        send(8, 40, 0, 40);          // R9 equal hold
        drain();

        cfg_period = 16'hFFFF;
        send(9, 65535, 65535, 0);    // R3 no wrap, slack -65535
        send(10, 1, 0, 65535);       // R5 slack -65534
        drain();

        cfg_period = 16'd500;
        cfg_base   = GRP_W'(4090);
        send(10, 499, 1, 0);         // R9 equal, none
        send(10, 499, 2, 0);         // R7 group wraps to 4
        send(4095, 300, 300, 301);   // R7 R6 both
        drain();

        // R8 backpressure with random stimulus and cycle strobes
        cyc_mode = 1;
        for (int mode = 1; mode <= 2; mode++) begin
            rdy_mode = mode;
            for (int i = 0; i < 300; i++) begin
                lcg = lcg * 1103515245 + 12345;
                send(int'(lcg[27:16]), (lcg[31:30] == 0) ? 0 : int'(lcg[9:0]),
                     int'(lcg[19:10]), (lcg[29]) ? int'(lcg[14:6]) : 0);
            end
            drain();
        end
        rdy_mode = 0;
        cyc_mode = 0;
        drain();

        chk(exp_q.size() == 0, "R8 no event lost", longint'(exp_q.size()), 0);
        finish_run();
    end

endmodule